// File: doc/BRIEF.md
# Masked Crate Busy Combiner

This block merges the busy signals of a crate into two levels. Sixteen per-slot busy lines arrive active-low. Each one passes through its own mask bit before it joins an OR, and a software busy bit also feeds that OR. The result is the crate busy level. A front-panel busy can arrive on either of two inputs, and it can join the module busy level only when its enable is set. Three internal sources can also raise module busy, each behind its own enable: test busy, burst busy and signal dead-time. The crate busy level itself reaches module busy only when the crate enable is set. In stand-alone mode, module busy is held high.

The slot and front-panel inputs are asynchronous, so each passes through a two-flop synchroniser first. The software bit, the enables, the mask and the internal sources are synchronous register-bank values. The raw crate, front-panel and module busy levels are brought out as status outputs.

Each indicator LED output has a retriggerable pulse stretcher, so that a one-cycle pulse stays visible for a parameterised number of cycles. At 40 MHz, 2,400,000 cycles gives about 60 ms. There is one LED per slot, which shows the unmasked slot busy, and one LED each for crate, front-panel and module busy.

Top module: `busy_combiner`

## Requirements
- R1: During and after reset, `crate_busy`, `ext_busy`, `module_busy` and every LED output are low.
- R2: A slot input `slot_busy_n[i]` at 0 means busy. `crate_busy` is the OR over i of (slot i busy AND `slot_mask[i]`=1), ORed with `sw_busy`. A slot input change shows on `crate_busy` three clock edges later.
- R3: A slot whose `slot_mask` bit is 0 has no effect on `crate_busy`. When all slot inputs are 1 (undriven slots pulled high) and `sw_busy` is 0, `crate_busy` is 0.
- R4: `sw_busy`=1 makes `crate_busy` 1 from the next clock edge, whatever the slots and mask hold.
- R5: `ext_busy` is the OR of `ext_busy_a` and `ext_busy_b`, both active-high, with three edges of latency. It raises `module_busy` only when `ext_en`=1.
- R6: Each of `test_busy`, `burst_busy` and `dead_busy` raises `module_busy` on the next edge only when its own enable (`test_en`, `burst_en`, `dead_en`) is 1.
- R7: `crate_busy` raises `module_busy` only when `crate_en`=1. The latency from a slot input to `module_busy` is three edges.
- R8: `standalone`=1 makes `module_busy` 1 from the next edge, whatever the other inputs hold.
- R9: An LED goes high on the edge after its source is high. It stays high while the source is high and for `STRETCH_CYCLES` edges after the source drops. A new pulse reloads the count. `led_slot[i]` follows the unmasked busy of slot i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_busy_n | input | 16 | Per-slot busy, active-low, asynchronous |
| ext_busy_a | input | 1 | Front-panel busy, first input, active-high, asynchronous |
| ext_busy_b | input | 1 | Front-panel busy, second input, active-high, asynchronous |
| slot_mask | input | 16 | 1 lets the slot join crate busy |
| sw_busy | input | 1 | Software busy bit into crate busy |
| crate_en | input | 1 | Lets crate busy raise module busy |
| ext_en | input | 1 | Lets front-panel busy raise module busy |
| test_busy | input | 1 | Internal test busy source |
| test_en | input | 1 | Enable for test busy |
| burst_busy | input | 1 | Internal burst busy source |
| burst_en | input | 1 | Enable for burst busy |
| dead_busy | input | 1 | Internal dead-time busy source |
| dead_en | input | 1 | Enable for dead-time busy |
| standalone | input | 1 | Stand-alone mode, forces module busy |
| crate_busy | output | 1 | Crate busy level (status) |
| ext_busy | output | 1 | Raw front-panel busy level (status) |
| module_busy | output | 1 | Module busy output (status) |
| led_slot | output | 16 | Stretched per-slot busy LEDs |
| led_crate | output | 1 | Stretched crate busy LED |
| led_ext | output | 1 | Stretched front-panel busy LED |
| led_module | output | 1 | Stretched module busy LED |

## Verification
The hardest behaviour to reach from the ports is retriggering. A second short pulse has to arrive while an LED is still stretching the first, and the LED must then hold past the point where the first pulse alone would have ended. The bench builds the block with a short stretch length. It sends a one-cycle slot pulse and a second pulse partway through the stretch, then samples the LED both after the first window would have closed and after the second window has closed. The rest of the masking and enabling logic is covered by random patterns of inputs, masks and enables held steady until they settle, alongside directed cases for all-masked, all-empty and stand-alone.

// File: rtl/busy_pkg.sv
// Package: shared helpers for the busy combiner.
// Assumes: synthesis-time constant widths only.
package busy_pkg;
    localparam int DEFAULT_SLOTS   = 16;
    localparam int DEFAULT_STAGES  = 2;
    localparam int DEFAULT_STRETCH = 2_400_000;

    // Counter width needed to hold the stretch length.
    function automatic int stretch_width(input int len);
        return (len < 2) ? 1 : $clog2(len + 1);
    endfunction
endpackage

// File: rtl/busy_sync.sv
// Module: busy_sync
// Multi-bit, multi-stage flop synchroniser. Each bit is independent.
// Assumes: STAGES >= 1; RST_VAL is the idle level of the lines.
module busy_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pulse_stretch.sv
// Module: pulse_stretch
// Retriggerable stretcher: output high while the trigger is high and for
// LEN cycles after it drops; each new trigger cycle reloads the count.
// Assumes: LEN >= 1; trigger is synchronous to clk.
module pulse_stretch
    import busy_pkg::*;
#(
    parameter int LEN = DEFAULT_STRETCH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic led
);
    localparam int            CW   = stretch_width(LEN);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] cnt_q;

    // Reload on trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (trig)            cnt_q <= LOAD;
        else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
    end

    assign led = (cnt_q != '0);
endmodule

// File: rtl/busy_combiner.sv
// Module: busy_combiner
// Combines masked active-low slot busy lines, a software bit, front-panel
// busy and gated internal sources into crate and module busy levels, and
// drives stretched indicator LEDs.
// Assumes: slot and front-panel inputs asynchronous; all control and
// internal sources synchronous to clk.
module busy_combiner
    import busy_pkg::*;
#(
    parameter int NUM_SLOTS      = DEFAULT_SLOTS,
    parameter int SYNC_STAGES    = DEFAULT_STAGES,
    parameter int STRETCH_CYCLES = DEFAULT_STRETCH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] slot_busy_n,
    input  logic                 ext_busy_a,
    input  logic                 ext_busy_b,
    input  logic [NUM_SLOTS-1:0] slot_mask,
    input  logic                 sw_busy,
    input  logic                 crate_en,
    input  logic                 ext_en,
    input  logic                 test_busy,
    input  logic                 test_en,
    input  logic                 burst_busy,
    input  logic                 burst_en,
    input  logic                 dead_busy,
    input  logic                 dead_en,
    input  logic                 standalone,
    output logic                 crate_busy,
    output logic                 ext_busy,
    output logic                 module_busy,
    output logic [NUM_SLOTS-1:0] led_slot,
    output logic                 led_crate,
    output logic                 led_ext,
    output logic                 led_module
);
    localparam int NUM_EXT = 2;

    logic [NUM_SLOTS-1:0] slot_sync_n;
    logic [NUM_SLOTS-1:0] slot_act;
    logic [NUM_EXT-1:0]   ext_sync;
    logic                 crate_raw;
    logic                 ext_raw;
    logic                 int_raw;
    logic                 crate_q, ext_q, module_q;

    busy_sync #(.W(NUM_SLOTS), .STAGES(SYNC_STAGES), .RST_VAL({NUM_SLOTS{1'b1}}))
        u_slot_sync (.clk(clk), .rst_n(rst_n), .d(slot_busy_n), .q(slot_sync_n));

    busy_sync #(.W(NUM_EXT), .STAGES(SYNC_STAGES), .RST_VAL('0))
        u_ext_sync (.clk(clk), .rst_n(rst_n), .d({ext_busy_b, ext_busy_a}), .q(ext_sync));

    // Form the combinational busy terms from the synchronised inputs.
    always_comb begin
        slot_act  = ~slot_sync_n;
        crate_raw = (|(slot_act & slot_mask)) | sw_busy;
        ext_raw   = |ext_sync;
        int_raw   = (test_busy & test_en) | (burst_busy & burst_en) | (dead_busy & dead_en);
    end

    // Register the three status levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crate_q  <= 1'b0;
            ext_q    <= 1'b0;
            module_q <= 1'b0;
        end else begin
            crate_q  <= crate_raw;
            ext_q    <= ext_raw;
            module_q <= standalone | (crate_en & crate_raw) | (ext_en & ext_raw) | int_raw;
        end
    end

    assign crate_busy  = crate_q;
    assign ext_busy    = ext_q;
    assign module_busy = module_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot_led
            pulse_stretch #(.LEN(STRETCH_CYCLES))
                u_led (.clk(clk), .rst_n(rst_n), .trig(slot_act[gi]), .led(led_slot[gi]));
        end
    endgenerate

    pulse_stretch #(.LEN(STRETCH_CYCLES))
        u_led_crate (.clk(clk), .rst_n(rst_n), .trig(crate_q), .led(led_crate));
    pulse_stretch #(.LEN(STRETCH_CYCLES))
        u_led_ext (.clk(clk), .rst_n(rst_n), .trig(ext_q), .led(led_ext));
    pulse_stretch #(.LEN(STRETCH_CYCLES))
        u_led_module (.clk(clk), .rst_n(rst_n), .trig(module_q), .led(led_module));
endmodule

// File: rtl/busy_combiner_chk.sv
// Module: busy_combiner_chk
// Checker bound to busy_combiner; relates ports across clock edges.
// Assumes: port names match the top module for the .* bind.
module busy_combiner_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_busy,
    input logic crate_en,
    input logic ext_en,
    input logic test_busy,
    input logic test_en,
    input logic burst_en,
    input logic dead_en,
    input logic standalone,
    input logic crate_busy,
    input logic module_busy,
    input logic led_crate,
    input logic led_module
);
    AST_STANDALONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(standalone)) |-> module_busy); // R8

    AST_SW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sw_busy)) |-> crate_busy); // R4

    AST_ALL_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(standalone) && !$past(crate_en) && !$past(ext_en)
         && !$past(test_en) && !$past(burst_en) && !$past(dead_en)) |-> !module_busy); // R6

    AST_TEST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(test_en) && $past(test_busy)) |-> module_busy); // R6

    AST_LED_CRATE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        crate_busy |=> led_crate); // R9

    AST_LED_MODULE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        module_busy |=> led_module); // R9
endmodule

bind busy_combiner busy_combiner_chk u_chk (.*);

// File: tb/tb_busy_combiner.sv
module tb_busy_combiner;
    localparam int NS  = 16;
    localparam int LEN = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] slot_busy_n = '1;
    logic ext_busy_a = 0, ext_busy_b = 0;
    logic [NS-1:0] slot_mask = '0;
    logic sw_busy = 0, crate_en = 0, ext_en = 0;
    logic test_busy = 0, test_en = 0, burst_busy = 0, burst_en = 0;
    logic dead_busy = 0, dead_en = 0, standalone = 0;
    logic crate_busy, ext_busy, module_busy, led_crate, led_ext, led_module;
    logic [NS-1:0] led_slot;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    busy_combiner #(.NUM_SLOTS(NS), .SYNC_STAGES(2), .STRETCH_CYCLES(LEN)) dut (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic exp_crate();
        return (|(~slot_busy_n & slot_mask)) | sw_busy;
    endfunction

    function automatic logic exp_ext();
        return ext_busy_a | ext_busy_b;
    endfunction

    function automatic logic exp_module();
        return standalone | (crate_en & exp_crate()) | (ext_en & exp_ext())
             | (test_busy & test_en) | (burst_busy & burst_en) | (dead_busy & dead_en);
    endfunction

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_levels(input string req);
        chk({req, " crate_busy"}, crate_busy, exp_crate());
        chk({req, " ext_busy"}, ext_busy, exp_ext());
        chk({req, " module_busy"}, module_busy, exp_module());
    endtask

    task automatic quiet();
        slot_busy_n = '1; ext_busy_a = 0; ext_busy_b = 0; sw_busy = 0;
        test_busy = 0; burst_busy = 0; dead_busy = 0; standalone = 0;
        crate_en = 0; ext_en = 0; test_en = 0; burst_en = 0; dead_en = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [31:0] r;
        seed = 32'h5eed_0001;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 crate_busy", crate_busy, 1'b0);
        chk("R1 module_busy", module_busy, 1'b0);
        chk("R1 led_module", led_module, 1'b0);
        chk("R1 led_slot any", |led_slot, 1'b0);
        rst_n = 1'b1;

        // R3: empty slots read not busy
        slot_mask = '1; settle();
        chk("R3 empty slots crate_busy", crate_busy, 1'b0);
        // R3: all busy but all masked off
        slot_mask = '0; slot_busy_n = '0; crate_en = 1; settle();
        chk("R3 masked crate_busy", crate_busy, 1'b0);
        chk("R7 masked module_busy", module_busy, 1'b0);
        // R2: top and bottom slot individually; latency of three edges
        quiet(); slot_mask = '1; crate_en = 1; settle();
        slot_busy_n[15] = 0;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R2 slot15 not yet", crate_busy, 1'b0);
        @(posedge clk); @(negedge clk);
        chk("R2 slot15 after 3", crate_busy, 1'b1);
        chk("R7 slot15 module", module_busy, 1'b1);
        slot_busy_n = '1; slot_busy_n[0] = 0; slot_mask = 16'h0001; settle();
        chk("R2 slot0 crate", crate_busy, 1'b1);
        slot_mask = 16'hFFFE; settle();
        chk("R3 slot0 masked", crate_busy, 1'b0);
        // R7: crate busy without crate enable
        slot_mask = 16'h0001; crate_en = 0; settle();
        chk("R7 crate_en off module", module_busy, 1'b0);
        // R4: software busy with nothing else
        quiet(); slot_mask = '0; sw_busy = 1; @(posedge clk); @(negedge clk);
        chk("R4 sw_busy next edge", crate_busy, 1'b1);
        // R5: front-panel busy gated
        quiet(); ext_busy_b = 1; settle();
        chk("R5 ext status", ext_busy, 1'b1);
        chk("R5 ext_en off module", module_busy, 1'b0);
        ext_en = 1; @(posedge clk); @(negedge clk);
        chk("R5 ext_en on module", module_busy, 1'b1);
        // R6: each internal source gated
        quiet(); dead_busy = 1; burst_busy = 1; test_busy = 1; settle();
        chk("R6 all disabled", module_busy, 1'b0);
        burst_en = 1; @(posedge clk); @(negedge clk);
        chk("R6 burst enabled", module_busy, 1'b1);
        // R8: stand-alone forces busy
        quiet(); standalone = 1; @(posedge clk); @(negedge clk);
        chk("R8 standalone", module_busy, 1'b1);
        standalone = 0;

        // Random patterns held until settled
        for (int i = 0; i < 300; i++) begin
            r = $urandom();
            slot_busy_n = 16'($urandom()) | 16'($urandom());
            slot_mask   = 16'($urandom());
            sw_busy = (r[3:0] == 0);
            ext_busy_a = r[4] & r[5]; ext_busy_b = r[6] & r[7];
            crate_en = r[8]; ext_en = r[9];
            test_busy = r[10]; test_en = r[11];
            burst_busy = r[12]; burst_en = r[13];
            dead_busy = r[14]; dead_en = r[15];
            standalone = (r[19:16] == 0);
            settle();
            check_levels("R2 R5 R6 R7 R8 random");
        end

        // R9: stretcher behaviour
        quiet(); slot_mask = '1; repeat (LEN + 10) @(posedge clk); @(negedge clk);
        chk("R9 led_crate idle", led_crate, 1'b0);
        slot_busy_n[3] = 0; @(negedge clk); slot_busy_n[3] = 1;
        repeat (12) @(posedge clk); @(negedge clk);
        chk("R9 led_crate stretched", led_crate, 1'b1);
        chk("R9 led_slot3 stretched", led_slot[3], 1'b1);
        chk("R9 led_slot4 quiet", led_slot[4], 1'b0);
        repeat (LEN + 5) @(posedge clk); @(negedge clk);
        chk("R9 led_crate expired", led_crate, 1'b0);
        chk("R9 led_slot3 expired", led_slot[3], 1'b0);
        // R9: retrigger
        slot_busy_n[3] = 0; @(negedge clk); slot_busy_n[3] = 1;
        repeat (15) @(posedge clk); @(negedge clk);
        slot_busy_n[3] = 0; @(negedge clk); slot_busy_n[3] = 1;
        repeat (15) @(posedge clk); @(negedge clk);
        chk("R9 led_crate retriggered", led_crate, 1'b1);
        chk("R9 led_slot3 retriggered", led_slot[3], 1'b1);
        repeat (15) @(posedge clk); @(negedge clk);
        chk("R9 led_crate after retrigger", led_crate, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule